// File: doc/BRIEF.md
# Vectored Multi-Channel Interrupt Controller

This block gathers interrupt events from a set of serial channels and one parallel-port source. Each serial channel owns two event status registers. The parallel port owns one. Every status bit latches its event whether or not it is masked. Only unmasked pending bits take part in raising the single request line and in vector generation. When the host runs an acknowledge cycle, the block drives one vector byte on its read data bus. The byte names the winning interrupt group and channel.

Groups 0, 1 and 2 map to bits 0, 1 and 2 of a channel's first status register. These indications clear themselves when the acknowledge that reported them completes. Every other bit reports as group 3, and it stays pending until software reads the owning status register. Reading a status register clears it. A summary register shows which status registers hold unmasked pending bits. Each acknowledge freezes this summary until one of a defined set of accesses releases it, so software sees a consistent snapshot of what was pending at acknowledge time.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every status register and the summary register read as zero, every mask register reads as all ones, and the request line is low.
- R2: An event pulse sets its status bit even when the bit is masked, and the bit stays readable. A masked pending bit neither raises the request line nor appears in the summary register.
- R3: The request line is high exactly when at least one status bit is pending and unmasked.
- R4: A read returns the register one cycle after the strobe, with read valid high. For status addresses (channel c, register r at address 2c+r; parallel status at 4·NCH) the read clears the register. An event that arrives in the same cycle as the read is not returned by that read, and it is set on the next cycle.
- R5: A vector is {group[1:0], 3'b000, channel[2:0]}. Priority runs from group 0 down to group 2, and then group 3. Within a group, a lower channel wins. The parallel port reports as group 3, channel 7, and ranks below every serial channel.
- R6: An acknowledge strobe sampled high drives the vector on the read data bus one cycle later with read valid high. If nothing is pending and unmasked, the vector is 8'hFF.
- R7: The bit that a group 0 to 2 vector reports is cleared by that acknowledge. A group 3 indication stays pending, and the request line stays high, until its status register is read.
- R8: Summary bit 2c+r shows unmasked pending bits in channel c register r. Bit 2·NCH shows the parallel port, and is kept separate from channel 7.
- R9: An acknowledge loads the summary with the live state and then freezes it. A summary read returns the frozen value and releases it. A status register read also releases it, and so does a new acknowledge. Once released, the summary follows the live state with one cycle of lag.
- R10: Mask registers sit at address 2·NCH+2c+r, with the parallel mask at 4·NCH+1. They are written over the bus, take effect on the next cycle and read back unchanged. The summary sits at 4·NCH+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev0_i | input | NCH*STAT_W | Event pulses for each channel's first status register |
| ev1_i | input | NCH*STAT_W | Event pulses for each channel's second status register |
| pev_i | input | STAT_W | Event pulses for the parallel-port status register |
| addr_i | input | ADDR_W | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe (mask registers) |
| wdata_i | input | STAT_W | Write data |
| inta_i | input | 1 | Acknowledge strobe |
| rdata_o | output | BUS_W | Read data or vector, valid one cycle after the strobe |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with four channels and four-bit status registers. This gives a 9-bit summary register and a 19-entry address map. That size lets the bench sweep every bit of every status register, masked and unmasked, through event, acknowledge, summary read and clear. Every vector and summary value the bench expects is worked out from the channel, register and bit index. The small configuration still keeps channel 7 free, so the parallel-port vector can be told apart. Directed sequences on the same configuration cover priority among mixed sources, a read that collides with an event, and each way of releasing a frozen summary.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    GRP_A    = 2'd0,
    GRP_B    = 2'd1,
    GRP_C    = 2'd2,
    GRP_CHAN = 2'd3
  } grp_e;

  localparam int          AUTO_GRPS = 3;
  localparam logic [7:0]  VEC_IDLE  = 8'hFF;
  localparam logic [2:0]  PAR_CH    = 3'd7;

  function automatic logic [7:0] pack_vec(input grp_e g, input logic [2:0] ch);
    return {g, 3'b000, ch};
  endfunction

endpackage

// File: rtl/ivc_stat_reg.sv
module ivc_stat_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic         rd_i,
  input  logic [W-1:0] clr_i,
  input  logic         mwr_i,
  input  logic [W-1:0] mdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] mask_q;

  // A read empties the register; events seen during the read are parked
  // in hold_q and merged on the first cycle without a read.
  always_comb begin
    if (rd_i) begin
      stat_d = '0;
      hold_d = hold_q | ev_i;
    end else begin
      stat_d = (stat_q & ~clr_i) | ev_i | hold_q;
      hold_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      hold_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      hold_q <= hold_d;
      if (mwr_i) mask_q <= mdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = stat_q & ~mask_q;

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && hold_q == '0 && ev_i == '0) |=> (stat_o == '0));

  assert_event_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i) |=> ((stat_o & $past(ev_i)) == $past(ev_i)));

endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc
  import ivc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int W   = 8
) (
  input  logic [NCH*W-1:0] pend0_i,
  input  logic [NCH*W-1:0] pend1_i,
  input  logic             ppend_i,
  output logic             hit_o,
  output grp_e             grp_o,
  output logic [2:0]       ch_o
);

  localparam int HI_W = W - AUTO_GRPS;

  // Scanned from lowest to highest priority; the last match wins.
  always_comb begin
    hit_o = 1'b0;
    grp_o = GRP_CHAN;
    ch_o  = '0;
    if (ppend_i) begin
      hit_o = 1'b1;
      grp_o = GRP_CHAN;
      ch_o  = PAR_CH;
    end
    for (int c = NCH - 1; c >= 0; c--) begin
      if ((|pend0_i[c*W+AUTO_GRPS +: HI_W]) || (|pend1_i[c*W +: W])) begin
        hit_o = 1'b1;
        grp_o = GRP_CHAN;
        ch_o  = 3'(c);
      end
    end
    for (int g = AUTO_GRPS - 1; g >= 0; g--) begin
      for (int c = NCH - 1; c >= 0; c--) begin
        if (pend0_i[c*W+g]) begin
          hit_o = 1'b1;
          grp_o = grp_e'(2'(g));
          ch_o  = 3'(c);
        end
      end
    end
  end

endmodule

// File: rtl/ivc_gis_ctl.sv
module ivc_gis_ctl #(
  parameter int GW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] live_i,
  input  logic          ack_i,
  input  logic          release_i,
  output logic [GW-1:0] gis_o
);

  logic          frozen_q, frozen_d;
  logic [GW-1:0] gis_q;
  logic          gis_en;

  always_comb begin
    gis_en = ack_i | ~frozen_q;
    if (ack_i)          frozen_d = 1'b1;
    else if (release_i) frozen_d = 1'b0;
    else                frozen_d = frozen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
      gis_q    <= '0;
    end else begin
      frozen_q <= frozen_d;
      if (gis_en) gis_q <= live_i;
    end
  end

  assign gis_o = gis_q;

  assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !ack_i) |=> $stable(gis_o));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int STAT_W = 8,
  localparam int SW     = NCH * STAT_W,
  localparam int GIS_W  = 2 * NCH + 1,
  localparam int BUS_W0 = (GIS_W > STAT_W) ? GIS_W : STAT_W,
  localparam int BUS_W  = (BUS_W0 > 8) ? BUS_W0 : 8,
  localparam int ADDR_W = $clog2(4 * NCH + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     ev0_i,
  input  logic [SW-1:0]     ev1_i,
  input  logic [STAT_W-1:0] pev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              inta_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);

  localparam int A_MASK0 = 2 * NCH;
  localparam int A_PIS   = 4 * NCH;
  localparam int A_PMASK = A_PIS + 1;
  localparam int A_GIS   = A_PIS + 2;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_m_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_q_n <= rst_m_q;
    end
  end

  logic [1:0][SW-1:0]  ev_all;
  logic [1:0][SW-1:0]  pend_all;
  logic [STAT_W-1:0]   st_a [2][NCH];
  logic [STAT_W-1:0]   mk_a [2][NCH];
  logic [GIS_W-1:0]    gis_live;
  logic [GIS_W-1:0]    gis_val;
  logic [STAT_W-1:0]   pst, pmk, ppd;

  logic                pick_hit;
  grp_e                pick_grp;
  logic [2:0]          pick_ch;
  logic                auto_fire;
  logic [STAT_W-1:0]   auto_bits;
  logic                rd_ok;

  assign ev_all    = {ev1_i, ev0_i};
  assign rd_ok     = rd_i & ~inta_i;
  assign auto_fire = inta_i & pick_hit & (pick_grp != GRP_CHAN);
  assign auto_bits = STAT_W'(1) << pick_grp;

  for (genvar r = 0; r < 2; r++) begin : g_reg
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic              rd_w, mwr_w;
      logic [STAT_W-1:0] clr_w, pd_w;

      assign rd_w  = rd_ok && (addr_i == ADDR_W'(2 * c + r));
      assign mwr_w = wr_i  && (addr_i == ADDR_W'(A_MASK0 + 2 * c + r));
      assign clr_w = (r == 0 && auto_fire && pick_ch == 3'(c)) ? auto_bits : '0;

      ivc_stat_reg #(.W(STAT_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_q_n),
        .ev_i    (ev_all[r][c*STAT_W +: STAT_W]),
        .rd_i    (rd_w),
        .clr_i   (clr_w),
        .mwr_i   (mwr_w),
        .mdata_i (wdata_i),
        .stat_o  (st_a[r][c]),
        .mask_o  (mk_a[r][c]),
        .pend_o  (pd_w)
      );

      assign pend_all[r][c*STAT_W +: STAT_W] = pd_w;
      assign gis_live[2 * c + r]             = |pd_w;
    end
  end

  ivc_stat_reg #(.W(STAT_W)) u_par (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ev_i    (pev_i),
    .rd_i    (rd_ok && addr_i == ADDR_W'(A_PIS)),
    .clr_i   ('0),
    .mwr_i   (wr_i && addr_i == ADDR_W'(A_PMASK)),
    .mdata_i (wdata_i),
    .stat_o  (pst),
    .mask_o  (pmk),
    .pend_o  (ppd)
  );

  assign gis_live[2 * NCH] = |ppd;
  assign irq_o             = |gis_live;

  ivc_prio_enc #(.NCH(NCH), .W(STAT_W)) u_prio (
    .pend0_i (pend_all[0]),
    .pend1_i (pend_all[1]),
    .ppend_i (|ppd),
    .hit_o   (pick_hit),
    .grp_o   (pick_grp),
    .ch_o    (pick_ch)
  );

  logic release_w;
  assign release_w = rd_ok && ((addr_i < ADDR_W'(2 * NCH)) ||
                               (addr_i == ADDR_W'(A_PIS)) ||
                               (addr_i == ADDR_W'(A_GIS)));

  ivc_gis_ctl #(.GW(GIS_W)) u_gis (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .live_i    (gis_live),
    .ack_i     (inta_i),
    .release_i (release_w),
    .gis_o     (gis_val)
  );

  // Read path
  logic [BUS_W-1:0] rd_sel, rdata_d;
  logic [7:0]       vec_w;

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 2; r++) begin
        if (addr_i == ADDR_W'(2 * c + r))           rd_sel = BUS_W'(st_a[r][c]);
        if (addr_i == ADDR_W'(A_MASK0 + 2 * c + r)) rd_sel = BUS_W'(mk_a[r][c]);
      end
    end
    if (addr_i == ADDR_W'(A_PIS))   rd_sel = BUS_W'(pst);
    if (addr_i == ADDR_W'(A_PMASK)) rd_sel = BUS_W'(pmk);
    if (addr_i == ADDR_W'(A_GIS))   rd_sel = BUS_W'(gis_val);

    vec_w = pick_hit ? pack_vec(pick_grp, pick_ch) : VEC_IDLE;
    if (inta_i)    rdata_d = BUS_W'(vec_w);
    else if (rd_i) rdata_d = rd_sel;
    else           rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rdata_o  <= rdata_d;
      rvalid_o <= inta_i | rd_i;
    end
  end

  assert_irq_agrees_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_o == pick_hit);

  assert_vec_layout_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (inta_i && pick_hit) |=> (rvalid_o && rdata_o[5:3] == 3'b000));

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int NCH = 4;
  localparam int SW  = 4;
  localparam int FW  = NCH * SW;
  localparam int AW  = 5;
  localparam int BW  = 9;
  localparam int A_MASK0 = 2 * NCH;
  localparam int A_PIS   = 4 * NCH;
  localparam int A_PMASK = A_PIS + 1;
  localparam int A_GIS   = A_PIS + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [FW-1:0] ev0, ev1;
  logic [SW-1:0] pev;
  logic [AW-1:0] addr;
  logic          rd, wr, inta;
  logic [SW-1:0] wdata;
  logic [BW-1:0] rdata;
  logic          rvalid, irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.NCH(NCH), .STAT_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev0_i(ev0), .ev1_i(ev1), .pev_i(pev),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .inta_i(inta),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input int a, output int val);
    @(negedge clk); addr = AW'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0; val = int'(rdata);
    @(negedge clk);
  endtask

  task automatic do_write(input int a, input int d);
    @(negedge clk); addr = AW'(a); wdata = SW'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_ack(output int val, output int vld);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0; val = int'(rdata); vld = int'(rvalid);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [FW-1:0] e0, input logic [FW-1:0] e1, input logic [SW-1:0] pe);
    @(negedge clk); ev0 = e0; ev1 = e1; pev = pe;
    @(negedge clk); ev0 = '0; ev1 = '0; pev = '0;
  endtask

  function automatic int vec(input int g, input int c);
    return (g << 6) | c;
  endfunction

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL R6 watchdog: actual hang, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, vl;
    rst_n = 1'b0; ev0 = '0; ev1 = '0; pev = '0; addr = '0;
    rd = 1'b0; wr = 1'b0; inta = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    for (int a = 0; a < 2 * NCH; a++) begin
      do_read(a, v);            chk("R1 status", v, 0);
      do_read(A_MASK0 + a, v);  chk("R1 mask", v, 'hF);
    end
    do_read(A_PIS, v);   chk("R1 par status", v, 0);
    do_read(A_PMASK, v); chk("R1 par mask", v, 'hF);
    do_read(A_GIS, v);   chk("R1 summary", v, 0);

    // R2/R8/R4 masked sweep
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 2; r++)
        for (int b = 0; b < SW; b++) begin
          logic [FW-1:0] e;
          e = FW'(1) << (c * SW + b);
          pulse(r == 0 ? e : '0, r == 1 ? e : '0, '0);
          chk("R2 masked irq", int'(irq), 0);
          do_read(A_GIS, v);       chk("R8 masked summary", v, 0);
          do_read(2 * c + r, v);   chk("R2 masked visible", v, 1 << b);
          do_read(2 * c + r, v);   chk("R4 cleared", v, 0);
        end

    // R3/R5/R6/R7/R8/R9 unmasked sweep
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 2; r++)
        for (int b = 0; b < SW; b++) begin
          logic [FW-1:0] e;
          int g, gi;
          e  = FW'(1) << (c * SW + b);
          g  = (r == 0 && b < 3) ? b : 3;
          gi = 1 << (2 * c + r);
          do_write(A_MASK0 + 2 * c + r, ~(1 << b) & 'hF);
          pulse(r == 0 ? e : '0, r == 1 ? e : '0, '0);
          chk("R3 irq raised", int'(irq), 1);
          do_ack(v, vl);
          chk("R6 ack valid", vl, 1);
          chk("R5 vector", v, vec(g, c));
          if (g < 3) begin
            chk("R7 auto clear irq", int'(irq), 0);
            do_read(A_GIS, v); chk("R9 frozen summary", v, gi);
            do_read(A_GIS, v); chk("R9 released summary", v, 0);
            do_read(2 * c + r, v); chk("R7 auto cleared bit", v, 0);
          end else begin
            chk("R7 group3 irq held", int'(irq), 1);
            do_read(A_GIS, v); chk("R8 summary bit", v, gi);
            do_read(2 * c + r, v); chk("R7 group3 read", v, 1 << b);
            chk("R3 irq dropped", int'(irq), 0);
            do_read(A_GIS, v); chk("R9 summary live", v, 0);
          end
          do_write(A_MASK0 + 2 * c + r, 'hF);
        end

    // Parallel port sweep (R5, R8)
    for (int b = 0; b < SW; b++) begin
      do_write(A_PMASK, ~(1 << b) & 'hF);
      pulse('0, '0, SW'(1 << b));
      do_ack(v, vl);      chk("R5 parallel vector", v, vec(3, 7));
      do_read(A_GIS, v);  chk("R8 parallel summary", v, 1 << (2 * NCH));
      do_read(A_PIS, v);  chk("R4 parallel read", v, 1 << b);
      chk("R3 parallel irq dropped", int'(irq), 0);
      do_write(A_PMASK, 'hF);
    end

    // R10 mask read back
    do_write(A_MASK0 + 3, 'h5);
    do_read(A_MASK0 + 3, v); chk("R10 mask readback", v, 'h5);

    // Unmask everything
    for (int a = 0; a < 2 * NCH; a++) do_write(A_MASK0 + a, 0);
    do_write(A_PMASK, 0);

    // R5 priority among mixed sources
    pulse((FW'(1) << 12) | (FW'(1) << 13) | (FW'(1) << 7) | (FW'(1) << 2),
          FW'(1) << 8, SW'(1));
    do_ack(v, vl); chk("R5 prio g0", v, vec(0, 3));
    do_ack(v, vl); chk("R5 prio g1", v, vec(1, 3));
    do_ack(v, vl); chk("R5 prio g2", v, vec(2, 0));
    do_ack(v, vl); chk("R5 prio g3 ch1", v, vec(3, 1));
    pulse(FW'(1) << 0, '0, '0);
    do_ack(v, vl); chk("R5 late higher priority", v, vec(0, 0));
    do_ack(v, vl); chk("R7 group3 repeats", v, vec(3, 1));
    do_read(2, v); chk("R4 ch1 read", v, 'h8);
    do_ack(v, vl); chk("R5 prio g3 ch2", v, vec(3, 2));
    do_read(5, v); chk("R4 ch2 read", v, 'h1);
    do_ack(v, vl); chk("R5 prio parallel last", v, vec(3, 7));
    do_read(A_PIS, v); chk("R4 par read", v, 'h1);
    do_ack(v, vl); chk("R6 idle vector", v, 'hFF);
    chk("R6 idle valid", vl, 1);
    chk("R3 all clear", int'(irq), 0);

    // R4 event colliding with a read
    pulse(FW'(1) << 1, '0, '0);
    @(negedge clk); addr = AW'(0); rd = 1'b1; ev0 = FW'(1) << 3;
    @(negedge clk); rd = 1'b0; ev0 = '0; v = int'(rdata);
    chk("R4 read excludes same-cycle event", v, 'h2);
    @(negedge clk);
    do_read(0, v); chk("R4 same-cycle event kept", v, 'h8);
    do_read(0, v); chk("R4 empty after", v, 0);

    // R9 freeze and release paths
    do_read(A_GIS, v);
    pulse('0, FW'(1) << 6, '0);
    do_ack(v, vl); chk("R9 ack vector", v, vec(3, 1));
    pulse('0, FW'(1) << 8, '0);
    do_read(A_GIS, v); chk("R9 frozen ignores new", v, 1 << 3);
    do_read(A_GIS, v); chk("R9 released by summary read", v, (1 << 3) | (1 << 5));
    do_ack(v, vl);
    pulse('0, FW'(1) << 1, '0);
    do_read(5, v); chk("R9 status read value", v, 'h1);
    do_read(A_GIS, v); chk("R9 released by status read", v, (1 << 3) | (1 << 1));
    do_read(3, v); chk("R4 ch1 r1 read", v, 'h4);
    do_read(1, v); chk("R4 ch0 r1 read", v, 'h2);
    chk("R3 final irq", int'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule